// File: doc/BRIEF.md
# Status Register Write-Protection Unit

This block keeps the 8-bit status byte of a serial memory and rules on every write that the command decoder wants to perform. The decoder reports each decoded event as a one-cycle strobe: the start of a new command, set-enable, clear-enable, a status write with its data byte, and one strobe for each byte of an array write, carrying that byte's address. The block answers each write strobe with a registered grant one cycle later. The status byte is also output for status reads.

A write is allowed only when three things agree. The write enable latch must be set. The protected address range, chosen by two range bits, must not contain the address. The lock bit, together with the external write-protect pin, must allow status writes. The write-protect pin is captured when a command starts, and that value is used for the whole command. Apart from the latch, the status bits stand in for non-volatile cells. Only the synchronous reset clears them. A separate power-up strobe clears the latch alone.

Top module: `sr_guard`

## Requirements
- R1: After reset the status byte is 00h and both grant outputs are 0.
- R2: A set-enable strobe makes status bit 1 (the latch) read 1 from the next cycle. A clear-enable strobe makes it read 0 from the next cycle.
- R3: A power-up strobe clears status bit 1 only. Bits 7..2 and bit 0 keep their values.
- R4: While the latch is 0, every array write and every status write is refused: its grant is 0 in the next cycle and the status byte does not change.
- R5: When a status write is accepted, bits 7..2 and bit 0 take the data byte and the status grant is 1 in the next cycle. The lock is bit 7, the range bits are bits 3:2, and the user bits are 6, 5, 4 and 0.
- R6: Bit 1 of a status write's data is ignored. Neither a status write nor an array write changes the latch.
- R7: With the lock bit at 1 and a captured write-protect value of 0, status writes are refused and the status byte is frozen. The freeze ends only with a command whose captured write-protect value is 1.
- R8: The write-protect pin is captured on the command-start strobe, or used directly if an event arrives in that same cycle. Changes later in the command have no effect.
- R9: Range bits 3:2 select the protected range. 00 protects nothing. 01 protects addresses at or above three quarters of the space (60000h..7FFFFh for 19 bits). 10 protects the upper half (40000h..7FFFFh). 11 protects everything. An array write inside the protected range gets grant 0.
- R10: Each byte strobe of a burst is judged on its own address, including after the address wraps from the top of the space back to 0.
- R11: The user bits 6, 5, 4 and 0 have no effect on any grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high cold reset; clears all status bits |
| pwr_up_i | input | 1 | Power-up strobe; clears only the latch |
| wp_n_i | input | 1 | Write-protect pin, active low |
| cmd_start_i | input | 1 | First cycle of a new command; captures wp_n_i |
| wen_i | input | 1 | Set-enable event |
| wdis_i | input | 1 | Clear-enable event |
| swr_i | input | 1 | Status write event |
| swr_data_i | input | 8 | Status write data byte |
| awr_i | input | 1 | Array write byte event |
| awr_addr_i | input | ADDR_W | Address of the array byte |
| status_o | output | 8 | Current status byte |
| awr_ok_o | output | 1 | Grant for the array byte of the previous cycle |
| swr_ok_o | output | 1 | Grant for the status write of the previous cycle |

## Verification
The bench uses the default 19-bit address width. This puts the exact range edges 3FFFFh/40000h, 5FFFFh/60000h and the top-to-zero wrap at 7FFFFh within reach of directed strobes. A behavioural model recomputes the status byte and both grants on every clock. The directed sequence walks through the lock freeze and release with the protect pin toggled inside and between commands.

// File: rtl/sr_guard_pkg.sv
package sr_guard_pkg;
  localparam int SR_W      = 8;
  localparam int BIT_LOCK  = 7;
  localparam int BIT_BPH   = 3;
  localparam int BIT_BPL   = 2;
  localparam int BIT_WEL   = 1;

  typedef enum logic [1:0] {
    RNG_NONE    = 2'b00,
    RNG_QUARTER = 2'b01,
    RNG_HALF    = 2'b10,
    RNG_ALL     = 2'b11
  } rng_e;
endpackage

// File: rtl/sr_guard_wp.sv
module sr_guard_wp (
  input  logic clk,
  input  logic rst,
  input  logic cmd_start_i,
  input  logic wp_n_i,
  input  logic lock_i,
  output logic hw_prot_o
);
  logic wp_q;
  logic wp_eff;

  always_ff @(posedge clk) begin
    if (rst)              wp_q <= 1'b1;
    else if (cmd_start_i) wp_q <= wp_n_i;
  end

  always_comb begin
    wp_eff    = cmd_start_i ? wp_n_i : wp_q;
    hw_prot_o = lock_i && !wp_eff;
  end
endmodule

// File: rtl/sr_guard_range.sv
module sr_guard_range
  import sr_guard_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        rng_i,
  output logic              hit_o
);
  localparam logic [ADDR_W-1:0] HALF_BASE = ADDR_W'(1) << (ADDR_W - 1);
  localparam logic [ADDR_W-1:0] QTR_BASE  = ADDR_W'(3) << (ADDR_W - 2);

  always_comb begin
    case (rng_e'(rng_i))
      RNG_NONE:    hit_o = 1'b0;
      RNG_QUARTER: hit_o = (addr_i >= QTR_BASE);
      RNG_HALF:    hit_o = (addr_i >= HALF_BASE);
      default:     hit_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/sr_guard_regs.sv
module sr_guard_regs
  import sr_guard_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            pwr_up_i,
  input  logic            wen_i,
  input  logic            wdis_i,
  input  logic            swr_take_i,
  input  logic [SR_W-1:0] swr_data_i,
  output logic [SR_W-1:0] sr_o
);
  logic [SR_W-1:0] sr_q;
  logic [SR_W-1:0] sr_d;

  always_comb begin
    sr_d = sr_q;
    if (pwr_up_i || wdis_i) begin
      sr_d[BIT_WEL] = 1'b0;
    end else if (wen_i) begin
      sr_d[BIT_WEL] = 1'b1;
    end else if (swr_take_i) begin
      sr_d          = swr_data_i;
      sr_d[BIT_WEL] = sr_q[BIT_WEL];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sr_q <= '0;
    else     sr_q <= sr_d;
  end

  assign sr_o = sr_q;
endmodule

// File: rtl/sr_guard.sv
module sr_guard
  import sr_guard_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_up_i,
  input  logic              wp_n_i,
  input  logic              cmd_start_i,
  input  logic              wen_i,
  input  logic              wdis_i,
  input  logic              swr_i,
  input  logic [7:0]        swr_data_i,
  input  logic              awr_i,
  input  logic [ADDR_W-1:0] awr_addr_i,
  output logic [7:0]        status_o,
  output logic              awr_ok_o,
  output logic              swr_ok_o
);
  logic [SR_W-1:0] sr;
  logic            hw_prot;
  logic            rng_hit;
  logic            swr_take;
  logic            other_evt;

  sr_guard_wp u_wp (
    .clk        (clk),
    .rst        (rst),
    .cmd_start_i(cmd_start_i),
    .wp_n_i     (wp_n_i),
    .lock_i     (sr[BIT_LOCK]),
    .hw_prot_o  (hw_prot)
  );

  sr_guard_range #(.ADDR_W(ADDR_W)) u_rng (
    .addr_i(awr_addr_i),
    .rng_i (sr[BIT_BPH:BIT_BPL]),
    .hit_o (rng_hit)
  );

  assign other_evt = pwr_up_i || wdis_i || wen_i;
  assign swr_take  = swr_i && !other_evt && sr[BIT_WEL] && !hw_prot;

  sr_guard_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .pwr_up_i  (pwr_up_i),
    .wen_i     (wen_i),
    .wdis_i    (wdis_i),
    .swr_take_i(swr_take),
    .swr_data_i(swr_data_i),
    .sr_o      (sr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      awr_ok_o <= 1'b0;
      swr_ok_o <= 1'b0;
    end else begin
      awr_ok_o <= awr_i && sr[BIT_WEL] && !rng_hit;
      swr_ok_o <= swr_take;
    end
  end

  assign status_o = sr;
endmodule

// File: rtl/sr_guard_chk.sv
module sr_guard_chk (
  input logic       clk,
  input logic       rst,
  input logic       pwr_up_i,
  input logic       wen_i,
  input logic       wdis_i,
  input logic       swr_i,
  input logic       awr_i,
  input logic [7:0] status_o,
  input logic       awr_ok_o,
  input logic       swr_ok_o
);
  a_r2_wen_sets: assert property (@(posedge clk) disable iff (rst)
    (wen_i && !wdis_i && !pwr_up_i) |=> status_o[1]);

  a_r2_wdis_clears: assert property (@(posedge clk) disable iff (rst)
    wdis_i |=> !status_o[1]);

  a_r3_pwr_keeps: assert property (@(posedge clk) disable iff (rst)
    pwr_up_i |=> (!status_o[1] && status_o[7:2] == $past(status_o[7:2])
                  && status_o[0] == $past(status_o[0])));

  a_r4_no_wel_awr: assert property (@(posedge clk) disable iff (rst)
    (awr_i && !status_o[1]) |=> !awr_ok_o);

  a_r4_no_wel_swr: assert property (@(posedge clk) disable iff (rst)
    (swr_i && !status_o[1]) |=> (!swr_ok_o && $stable(status_o)));

  a_r5_grant_needs_wel: assert property (@(posedge clk) disable iff (rst)
    swr_ok_o |-> $past(status_o[1]));

  a_r6_latch_kept: assert property (@(posedge clk) disable iff (rst)
    ((swr_i || awr_i) && !wen_i && !wdis_i && !pwr_up_i)
      |=> status_o[1] == $past(status_o[1]));

  a_r9_all_protected: assert property (@(posedge clk) disable iff (rst)
    (awr_i && status_o[3:2] == 2'b11) |=> !awr_ok_o);

  a_r2_quiet_stable: assert property (@(posedge clk) disable iff (rst)
    (!swr_i && !wen_i && !wdis_i && !pwr_up_i) |=> $stable(status_o));
endmodule

bind sr_guard sr_guard_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .pwr_up_i(pwr_up_i),
  .wen_i   (wen_i),
  .wdis_i  (wdis_i),
  .swr_i   (swr_i),
  .awr_i   (awr_i),
  .status_o(status_o),
  .awr_ok_o(awr_ok_o),
  .swr_ok_o(swr_ok_o)
);

// File: tb/sr_guard_test.sv
module sr_guard_test;
  localparam int AW = 19;

  logic clk = 0;
  logic rst = 1;
  logic pwr_up = 0, wp_n = 1, cmd_start = 0, wen = 0, wdis = 0, swr = 0, awr = 0;
  logic [7:0] sdata = 0;
  logic [AW-1:0] addr = 0;
  logic [7:0] status;
  logic awr_ok, swr_ok;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sr_guard #(.ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .pwr_up_i(pwr_up), .wp_n_i(wp_n),
    .cmd_start_i(cmd_start), .wen_i(wen), .wdis_i(wdis), .swr_i(swr),
    .swr_data_i(sdata), .awr_i(awr), .awr_addr_i(addr),
    .status_o(status), .awr_ok_o(awr_ok), .swr_ok_o(swr_ok)
  );

  // behavioural reference
  logic [7:0] m_sr;
  logic m_wpq, m_awr, m_swr;
  logic wp_now, prot;
  int   ai;
  always @(posedge clk) begin
    if (rst) begin
      m_sr <= 0; m_wpq <= 1; m_awr <= 0; m_swr <= 0;
    end else begin
      wp_now = cmd_start ? wp_n : m_wpq;
      if (cmd_start) m_wpq <= wp_n;
      m_awr <= 0; m_swr <= 0;
      if (pwr_up || wdis) m_sr[1] <= 0;
      else if (wen) m_sr[1] <= 1;
      else if (swr) begin
        if (m_sr[1] && (!m_sr[7] || wp_now)) begin
          m_swr <= 1;
          m_sr  <= {sdata[7:2], m_sr[1], sdata[0]};
        end
      end
      if (awr) begin
        ai = int'(addr);
        case (m_sr[3:2])
          2'b00: prot = 0;
          2'b01: prot = (ai >= 'h60000);
          2'b10: prot = (ai >= 'h40000);
          default: prot = 1;
        endcase
        m_awr <= m_sr[1] && !prot;
      end
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  always @(negedge clk) if (!rst && !done) begin
    chk("R5 model status", status, m_sr);
    chk("R9 model array grant", awr_ok, m_awr);
    chk("R7 model status grant", swr_ok, m_swr);
  end

  task automatic cyc(); @(posedge clk); @(negedge clk); endtask
  task automatic start_cmd(input logic w);
    wp_n = w; cmd_start = 1; cyc(); cmd_start = 0;
  endtask
  task automatic do_wen();  wen = 1;  cyc(); wen = 0;  endtask
  task automatic do_wdis(); wdis = 1; cyc(); wdis = 0; endtask
  task automatic do_swr(input logic [7:0] d);
    sdata = d; swr = 1; cyc(); swr = 0;
  endtask
  task automatic do_awr(input logic [AW-1:0] a);
    addr = a; awr = 1; cyc(); awr = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) cyc();
    rst = 0;
    cyc();
    chk("R1 status", status, 8'h00);
    chk("R1 awr grant", awr_ok, 0);
    chk("R1 swr grant", swr_ok, 0);

    start_cmd(1); do_awr('h00000); chk("R4 awr refused", awr_ok, 0);
    start_cmd(1); do_swr(8'hFF);
    chk("R4 swr refused", swr_ok, 0); chk("R4 status kept", status, 8'h00);

    start_cmd(1); do_wen(); chk("R2 latch set", status, 8'h02);
    start_cmd(1); do_swr(8'h00);
    chk("R6 latch not cleared by data", status, 8'h02); chk("R5 grant", swr_ok, 1);
    start_cmd(1); do_swr(8'h71);
    chk("R5 user bits written", status, 8'h73);
    start_cmd(1); do_awr('h7FFFF); chk("R11 user bits no effect", awr_ok, 1);

    start_cmd(1); do_swr(8'h04); chk("R5 range 01", status, 8'h06);
    start_cmd(1); do_awr('h5FFFF); chk("R9 below quarter", awr_ok, 1);
    do_awr('h60000); chk("R9 quarter edge", awr_ok, 0);
    do_awr('h7FFFF); chk("R10 top byte", awr_ok, 0);
    do_awr('h00000); chk("R10 after wrap", awr_ok, 1);

    start_cmd(1); do_swr(8'h08); chk("R5 range 10", status, 8'h0A);
    start_cmd(1); do_awr('h3FFFF); chk("R9 below half", awr_ok, 1);
    do_awr('h40000); chk("R9 half edge", awr_ok, 0);

    start_cmd(1); do_swr(8'h0C);
    start_cmd(1); do_awr('h00000); chk("R9 all protected", awr_ok, 0);
    chk("R6 latch after array write", status, 8'h0E);

    start_cmd(1); wp_n = 0; do_swr(8'h8C);
    chk("R8 mid-command pin drop ignored", swr_ok, 1);
    chk("R8 status", status, 8'h8E);
    start_cmd(0); do_swr(8'h00);
    chk("R7 frozen grant", swr_ok, 0); chk("R7 frozen status", status, 8'h8E);
    wp_n = 1; do_swr(8'h00);
    chk("R8 mid-command pin rise ignored", swr_ok, 0);
    start_cmd(1); do_swr(8'h80);
    chk("R7 freeze left", swr_ok, 1); chk("R7 status", status, 8'h82);

    start_cmd(1); pwr_up = 1; cyc(); pwr_up = 0;
    chk("R3 only latch cleared", status, 8'h80);
    start_cmd(1); do_wen(); start_cmd(1); do_wdis();
    chk("R2 latch cleared", status, 8'h80);
    repeat (3) cyc();
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule